// File: doc/BRIEF.md
# Transmit VLAN Tag Inserter

This block sits in a byte-wide transmit path ahead of checksum generation. For each frame it can add an IEEE 802.1Q tag right after the two MAC addresses. The caller asks for a tag through a per-frame request flag and a 16-bit tag value, both given with the first byte of the frame. The block does not add a tag when the frame already carries the 0x8100 type. To make that decision it holds back the two type bytes and only then emits either the four tag bytes or the original type.

After any insertion, the block counts the bytes it puts out and checks the total against a maximum length. The limit depends on two things: whether the frame ends up tagged, and whether jumbo mode is selected. An oversized frame is still forwarded in full. The error flag is raised together with its last byte, so that logic further down can drop or abort the frame.

Both sides use a valid/ready handshake with a last-byte marker. Backpressure on the output is honoured at all times, including while the block is emitting bytes that it generates itself.

Top module: `vtag_inserter`

## Requirements
- R1: A tag is inserted only when all three conditions hold:
  - the request flag was high with the first byte;
  - the frame has at least 14 bytes;
  - input bytes 12 and 13 are not 0x81 followed by 0x00.
- R2: When a tag is inserted, the output frame is built in this order:
  - input bytes 0 to 11;
  - 0x81, 0x00, tag bits 15:8, tag bits 7:0;
  - input bytes 12 to the end.

  The output frame is therefore 4 bytes longer than the input frame.
- R3: Without insertion, the output frame matches the input frame byte for byte and in length. This includes frames shorter than 14 bytes.
- R4: The request flag, tag value and jumbo select are sampled with the first byte of a frame. Changes to them during the rest of the frame have no effect.
- R5: The length limit is counted over output bytes and excludes the FCS. The limits are:

  | Mode | Untagged | Tagged |
  |---|---|---|
  | Normal | 1514 | 1518 |
  | Jumbo | 9212 | 9216 |

  A frame counts as tagged if a tag was inserted, or if it has at least 14 bytes and its bytes 12–13 are 0x81, 0x00.
- R6: The too-long flag is high exactly on the last output byte of a frame whose output length exceeds its limit. It is low on every other byte. The frame is forwarded completely either way.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values and `out_valid` stays high. This assumes the input side holds its values while stalled in the same way.
- R8: While the four inserted tag bytes are presented, `in_ready` is low.
- R9: After reset, with no input offered, `out_valid` and `out_too_long` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Last byte of the input frame |
| in_tag_req | input | 1 | Insert-tag request, sampled with the first byte |
| in_tag | input | 16 | Tag value to insert, sampled with the first byte |
| in_jumbo | input | 1 | Jumbo length limits, sampled with the first byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Last byte of the output frame |
| out_too_long | output | 1 | Frame exceeds its length limit, high with the last byte |

## Verification
The hardest cases to reach sit at the type field:
- frames that end while bytes 12 or 13 are still held back;
- the four-byte stall on the input while tag bytes go out under random output backpressure.

The bench sweeps every frame length from 1 to 18 with and without a request, under random input gaps and output stalls, so that every path through the held-back type bytes is exercised. It then places frames exactly on, and one byte past, each of the four length limits. It also flips the sampled controls after the first byte of every frame.

// File: rtl/vtag_pkg.sv
// Shared constants and types for the transmit tag inserter.
// Assumes byte-wide frames whose type field follows two 6-byte addresses.
package vtag_pkg;
    localparam int          TYPE_OFS  = 12;       // first byte of the type field
    localparam int          TAG_BYTES = 4;        // bytes added by one tag
    localparam logic [15:0] TPID      = 16'h8100; // tagged-frame type value

    // Position of the stream path within a frame
    typedef enum logic [2:0] {
        ST_HEAD,   // passing address bytes
        ST_B12,    // absorbing first type byte
        ST_B13,    // absorbing second type byte, deciding
        ST_TAG,    // emitting generated tag bytes
        ST_H0,     // emitting held first type byte
        ST_H1,     // emitting held second type byte
        ST_BODY    // passing payload bytes
    } vtag_state_e;
endpackage

// File: rtl/vtag_hdr_path.sv
// Stream path of the tag inserter. Passes address and payload bytes straight
// through, holds back the two type bytes, decides on insertion and emits
// the tag bytes while stalling the input. Assumes the upstream side keeps
// its byte stable while stalled.
module vtag_hdr_path
    import vtag_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    input  logic        in_tag_req,
    input  logic [15:0] in_tag,
    input  logic        in_jumbo,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        frame_tagged,
    output logic        frame_jumbo
);
    localparam int HIDX_W = $clog2(TYPE_OFS);

    vtag_state_e        state;
    logic [HIDX_W-1:0]  hidx;
    logic [1:0]         tidx;
    logic [7:0]         hold0, hold1;
    logic               h0_last, h1_last;
    logic               req_q, jumbo_q, tagged_q;
    logic [15:0]        tag_q;
    logic               first_beat;
    logic               in_fire, out_fire;
    logic               type_is_tpid;
    logic [7:0]         tag_byte;

    assign first_beat   = (state == ST_HEAD) && (hidx == '0);
    assign in_fire      = in_valid && in_ready;
    assign out_fire     = out_valid && out_ready;
    assign type_is_tpid = (hold0 == TPID[15:8]) && (in_data == TPID[7:0]);

    // Pick the generated tag byte for the current tag beat
    always_comb begin
        case (tidx)
            2'd0:    tag_byte = TPID[15:8];
            2'd1:    tag_byte = TPID[7:0];
            2'd2:    tag_byte = tag_q[15:8];
            default: tag_byte = tag_q[7:0];
        endcase
    end

    // Drive both handshakes and the output byte from the current state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = in_data;
        out_last  = in_last;
        case (state)
            ST_HEAD, ST_BODY: begin
                in_ready  = out_ready;
                out_valid = in_valid;
            end
            ST_B12, ST_B13: begin
                in_ready  = 1'b1;
            end
            ST_TAG: begin
                out_valid = 1'b1;
                out_data  = tag_byte;
                out_last  = 1'b0;
            end
            ST_H0: begin
                out_valid = 1'b1;
                out_data  = hold0;
                out_last  = h0_last;
            end
            ST_H1: begin
                out_valid = 1'b1;
                out_data  = hold1;
                out_last  = h1_last;
            end
            default: ;
        endcase
    end

    // Frame attributes seen by the length check (live on the first beat)
    assign frame_jumbo  = first_beat ? in_jumbo : jumbo_q;
    assign frame_tagged = first_beat ? 1'b0     : tagged_q;

    // Advance through the frame and capture per-frame controls and type bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HEAD;
            hidx     <= '0;
            tidx     <= '0;
            hold0    <= '0;
            hold1    <= '0;
            h0_last  <= 1'b0;
            h1_last  <= 1'b0;
            req_q    <= 1'b0;
            jumbo_q  <= 1'b0;
            tagged_q <= 1'b0;
            tag_q    <= '0;
        end else begin
            case (state)
                ST_HEAD: if (in_fire) begin
                    if (hidx == '0) begin
                        req_q    <= in_tag_req;
                        tag_q    <= in_tag;
                        jumbo_q  <= in_jumbo;
                        tagged_q <= 1'b0;
                    end
                    if (in_last) begin
                        hidx <= '0;
                    end else if (hidx == HIDX_W'(TYPE_OFS - 1)) begin
                        hidx  <= '0;
                        state <= ST_B12;
                    end else begin
                        hidx <= hidx + 1'b1;
                    end
                end
                ST_B12: if (in_valid) begin
                    hold0   <= in_data;
                    h0_last <= in_last;
                    state   <= in_last ? ST_H0 : ST_B13;
                end
                ST_B13: if (in_valid) begin
                    hold1    <= in_data;
                    h1_last  <= in_last;
                    tagged_q <= type_is_tpid || req_q;
                    tidx     <= '0;
                    state    <= (req_q && !type_is_tpid) ? ST_TAG : ST_H0;
                end
                ST_TAG: if (out_ready) begin
                    tidx <= tidx + 1'b1;
                    if (tidx == 2'd3) state <= ST_H0;
                end
                ST_H0: if (out_ready) begin
                    state <= h0_last ? ST_HEAD : ST_H1;
                end
                ST_H1: if (out_ready) begin
                    state <= h1_last ? ST_HEAD : ST_BODY;
                end
                ST_BODY: if (in_fire && in_last) begin
                    state <= ST_HEAD;
                end
                default: state <= ST_HEAD;
            endcase
        end
    end

    // Generated and held bytes stay put while the output is stalled
    p_gen_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TAG || state == ST_H0 || state == ST_H1) && !out_ready)
        |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // No input byte is taken while tag bytes are being emitted
    p_no_input_in_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAG) |-> !in_fire);

    // Without a request the decision never leads into tag emission
    p_no_req_no_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_B13 && in_valid && !req_q) |=> (state != ST_TAG));

    // Four tag beats, then the held type byte follows
    p_tag_then_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAG && tidx == 2'd3 && out_ready) |=> (state == ST_H0));
endmodule

// File: rtl/vtag_len_check.sv
// Output-side length check. Counts accepted output bytes of the current
// frame and flags the last byte when the frame exceeds its limit.
// Assumes frame_tagged and frame_jumbo are valid on every beat of a frame.
module vtag_len_check #(
    parameter int STD_MAX   = 1514,
    parameter int JUMBO_MAX = 9212,
    parameter int TAG_BYTES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_valid,
    input  logic beat_ready,
    input  logic beat_last,
    input  logic frame_tagged,
    input  logic frame_jumbo,
    output logic too_long
);
    localparam int LIM_MAX = JUMBO_MAX + TAG_BYTES;
    localparam int CNT_W   = $clog2(LIM_MAX + 2);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   next_len;
    logic [CNT_W:0]   limit;
    logic             beat_fire;

    assign beat_fire = beat_valid && beat_ready;
    assign next_len  = {1'b0, cnt} + 1'b1;

    // Select the limit for this frame's mode and tag state
    always_comb begin
        limit = frame_jumbo ? (CNT_W+1)'(JUMBO_MAX) : (CNT_W+1)'(STD_MAX);
        if (frame_tagged) limit = limit + (CNT_W+1)'(TAG_BYTES);
    end

    assign too_long = beat_valid && beat_last && (next_len > limit);

    // Count output bytes of the frame, saturating, cleared after the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (beat_fire) begin
            if (beat_last)      cnt <= '0;
            else if (cnt != '1) cnt <= cnt + 1'b1;
        end
    end

    // The count only moves on accepted beats
    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_fire |=> $stable(cnt));

    // A new frame always starts counting from zero
    p_cnt_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && beat_last) |=> (cnt == '0));
endmodule

// File: rtl/vtag_inserter.sv
// Top of the transmit tag inserter: stream path followed by the output-side
// length check. Assumes a byte-wide valid/ready stream with a last marker.
module vtag_inserter #(
    parameter int STD_MAX   = 1514,
    parameter int JUMBO_MAX = 9212
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    input  logic        in_tag_req,
    input  logic [15:0] in_tag,
    input  logic        in_jumbo,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        out_too_long
);
    logic frame_tagged, frame_jumbo;

    // Stream path: hold type bytes, decide, insert tag
    vtag_hdr_path u_path (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .in_last      (in_last),
        .in_tag_req   (in_tag_req),
        .in_tag       (in_tag),
        .in_jumbo     (in_jumbo),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_data     (out_data),
        .out_last     (out_last),
        .frame_tagged (frame_tagged),
        .frame_jumbo  (frame_jumbo)
    );

    // Length check on the bytes actually emitted
    vtag_len_check #(
        .STD_MAX   (STD_MAX),
        .JUMBO_MAX (JUMBO_MAX),
        .TAG_BYTES (vtag_pkg::TAG_BYTES)
    ) u_len (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat_valid   (out_valid),
        .beat_ready   (out_ready),
        .beat_last    (out_last),
        .frame_tagged (frame_tagged),
        .frame_jumbo  (frame_jumbo),
        .too_long     (out_too_long)
    );

    // The error flag appears only on a presented last byte
    p_err_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_too_long |-> (out_valid && out_last));
endmodule

// File: tb/tb_vtag_inserter.sv
module tb_vtag_inserter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_tag_req = 1'b0;
    logic [15:0] in_tag = '0;
    logic        in_jumbo = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        out_last;
    logic        out_too_long;

    int tests = 0;
    int fails = 0;
    int gap_pct = 0;
    int bp_pct  = 0;
    logic [7:0] exp_q[$];
    bit exp_err;
    bit exp_ins;

    vtag_inserter dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_tag_req(in_tag_req), .in_tag(in_tag),
        .in_jumbo(in_jumbo), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .out_too_long(out_too_long)
    );

    always #5 clk = ~clk;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] gen_byte(int i, int len, logic [15:0] typ);
        if (i == 12) return typ[15:8];
        if (i == 13) return typ[7:0];
        return 8'(i * 37 + len + 3);
    endfunction

    // Output-side stall pattern
    initial forever begin
        @(negedge clk);
        out_ready = (bp_pct == 0) ? 1'b1 : (($urandom % 100) >= bp_pct);
    end

    task automatic drive(int len, bit req, logic [15:0] tag, bit jmb, logic [15:0] typ);
        int  i = 0;
        bit  fresh = 1'b1;
        while (i < len) begin
            @(negedge clk);
            if (fresh && gap_pct != 0 && ($urandom % 100) < gap_pct) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_data  = gen_byte(i, len, typ);
                in_last  = (i == len - 1);
                // R4: controls only count with the first byte; scramble after
                in_tag_req = (i == 0) ? req : ~req;
                in_tag     = (i == 0) ? tag : ~tag;
                in_jumbo   = (i == 0) ? jmb : ~jmb;
            end
            #2;
            fresh = in_valid && in_ready;
            if (fresh) i++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic collect(int len);
        int  k = 0;
        int  bad = 0;
        int  first_bad = -1;
        int  err_mid = 0;
        int  tag_rdy = 0;
        int  unstable = 0;
        bit  stall = 1'b0;
        bit  done = 1'b0;
        bit  err_last = 1'b0;
        logic [7:0] pdata = '0;
        logic       plast = 1'b0;
        while (!done) begin
            @(negedge clk);
            #3;
            if (stall && (!out_valid || out_data !== pdata || out_last !== plast))
                unstable++;
            if (out_valid && exp_ins && k >= 12 && k <= 15 && in_ready) tag_rdy++;
            if (out_valid && out_ready) begin
                if (k >= exp_q.size() || out_data !== exp_q[k]) begin
                    bad++;
                    if (first_bad < 0) first_bad = k;
                end
                if (out_last) begin
                    err_last = out_too_long;
                    done = 1'b1;
                end else if (out_too_long) begin
                    err_mid++;
                end
                k++;
            end
            stall = out_valid && !out_ready;
            pdata = out_data;
            plast = out_last;
        end
        chk(bad == 0, exp_ins ? "R2" : "R3", $sformatf("byte mismatch (len %0d, first at %0d)", len, first_bad), bad, 0);
        chk(k == exp_q.size(), exp_ins ? "R2" : "R3", $sformatf("output length (in len %0d)", len), k, exp_q.size());
        chk(err_last == exp_err, "R5", $sformatf("too-long on last (len %0d)", len), int'(err_last), int'(exp_err));
        chk(err_mid == 0, "R6", "too-long on non-last beat", err_mid, 0);
        chk(unstable == 0, "R7", "output changed while stalled", unstable, 0);
        if (exp_ins) chk(tag_rdy == 0, "R8", "in_ready high during tag bytes", tag_rdy, 0);
    endtask

    task automatic run(int len, bit req, logic [15:0] tag, bit jmb, logic [15:0] typ);
        bit pretag;
        int olen;
        int lim;
        exp_q.delete();
        exp_ins = req && len >= 14 && typ != 16'h8100;   // R1
        pretag  = len >= 14 && typ == 16'h8100;
        for (int i = 0; i < len; i++) begin
            if (exp_ins && i == 12) begin
                exp_q.push_back(8'h81);
                exp_q.push_back(8'h00);
                exp_q.push_back(tag[15:8]);
                exp_q.push_back(tag[7:0]);
            end
            exp_q.push_back(gen_byte(i, len, typ));
        end
        olen = exp_q.size();
        lim  = (jmb ? 9212 : 1514) + ((exp_ins || pretag) ? 4 : 0);
        exp_err = olen > lim;
        fork
            drive(len, req, tag, jmb, typ);
            collect(len);
        join
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R9: idle after reset
        chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
        chk(out_too_long == 1'b0, "R9", "out_too_long after reset", int'(out_too_long), 0);

        // R1/R3: every short length, with and without request, under stalls
        gap_pct = 30; bp_pct = 30;
        for (int len = 1; len <= 18; len++) begin
            run(len, 1'b0, 16'hA5C3 ^ 16'(len), 1'b0, 16'h0800);
            run(len, 1'b1, 16'h5A3C ^ 16'(len), 1'b0, 16'h0800);
        end
        // R1: already tagged type suppresses insertion; near miss still inserts
        run(14, 1'b1, 16'h1234, 1'b0, 16'h8100);
        run(60, 1'b1, 16'h1234, 1'b0, 16'h8100);
        run(60, 1'b1, 16'hBEEF, 1'b0, 16'h8101);
        run(60, 1'b1, 16'hBEEF, 1'b0, 16'h0081);

        // R5/R6: normal-mode limits, one either side
        gap_pct = 10; bp_pct = 20;
        run(1514, 1'b0, 16'h0001, 1'b0, 16'h0800);
        run(1515, 1'b0, 16'h0001, 1'b0, 16'h0800);
        run(1514, 1'b1, 16'h0F0F, 1'b0, 16'h0800);
        run(1515, 1'b1, 16'h0F0F, 1'b0, 16'h0800);
        run(1518, 1'b0, 16'h0000, 1'b0, 16'h8100);
        run(1519, 1'b0, 16'h0000, 1'b0, 16'h8100);

        // R5: jumbo limits (jumbo select is flipped after byte 0, R4)
        gap_pct = 0; bp_pct = 0;
        run(9212, 1'b0, 16'h0002, 1'b1, 16'h0800);
        run(9213, 1'b0, 16'h0002, 1'b1, 16'h0800);
        run(9212, 1'b1, 16'hC001, 1'b1, 16'h0800);
        run(9213, 1'b1, 16'hC001, 1'b1, 16'h0800);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule